// File: doc/BRIEF.md
# Codec Power Sequencer

This block decides when a frame-based voice codec's digital core and its analog section may run. It samples an active-low power-down/reset pin on the fast processing clock. A low level only takes effect once it has been held long enough. The block also accepts two control-register bits that switch off the analog section and the digital section independently. It drives enables for both sections, a one-cycle reset for the coding engine, and output enables for the pins that must float while the chip sleeps.

Waking up needs three things: the pin is high, the processing clock is running, and a transmit or receive frame strobe arrives. The clock condition is implied, because nothing in the block advances without it. After a wake, the serial transmit-data pin stays floating until a set number of transmit frame strobes have passed, so that no half-formed sample reaches the line. The pin and both strobes are asynchronous. Each passes through a synchronizer before use.

Top module: `pwrseq_ctrl`

## Requirements
- R1: The pin must be sampled low (after the synchronizer) on at least LOW_CYCLES (default 10) consecutive processing-clock edges to force power-down. Any shorter low pulse has no effect: the data output enable stays high and no core reset is issued.
- R2: Setting `reg_pd_digital` forces the sequencer into power-down. `digital_en`, `oe_scp` and `oe_dt` drop, and clearing the bit starts a fresh wake-up.
- R3: Setting `reg_pd_analog` drops only `analog_en`; the digital outputs are unaffected. Setting `reg_pd_digital` alone leaves `analog_en` unchanged.
- R4: During a pin power-down, `analog_en`, `digital_en`, `oe_scp` and `oe_dt` are all low.
- R5: Leaving power-down requires the pin high and a rising edge on `fs_tx` or `fs_rx`. With the clock running but no strobe edge, `digital_en` stays low.
- R6: Each exit from power-down, including the first after `arst_n`, raises `core_rst` for exactly one clock cycle.
- R7: After the waking strobe edge, `oe_dt` stays low until HOLD_FRAMES (default 2) further rising edges of `fs_tx` have been seen. Edges of `fs_rx` do not count toward this.
- R8: While `arst_n` is low, every output is low.
- R9: A power-down request from the pin or from the register takes effect from any state, including the frame hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| pd_pin_n | input | 1 | Power-down/reset pin, active low, asynchronous |
| fs_tx | input | 1 | Transmit frame strobe, asynchronous |
| fs_rx | input | 1 | Receive frame strobe, asynchronous |
| reg_pd_analog | input | 1 | Register bit: switch off the analog section |
| reg_pd_digital | input | 1 | Register bit: switch off the digital section |
| analog_en | output | 1 | Analog section enable; also enables the reference and driver pins |
| digital_en | output | 1 | Digital core enable |
| core_rst | output | 1 | One-cycle reset of the coding engine to its initial state |
| oe_scp | output | 1 | Output enable of the serial control transmit pin |
| oe_dt | output | 1 | Output enable of the transmit data pin |

## Verification
The case hardest to reach from the ports is the boundary of the pin filter. Because of the synchronizer delay, a pulse of LOW_CYCLES−1 and a pulse of LOW_CYCLES look the same for several cycles. The bench therefore drives low pulses of exact lengths from a table that straddles the threshold, and judges each one by `oe_dt` and the count of `core_rst` pulses. The frame hold phase is also hard to stay in, because `fs_tx` edges leave it quickly. The bench wakes the block with `fs_rx` strobes only, confirms that it stays held, and then requests power-down while it is in that phase.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PWR_DOWN   = 2'd0,
    WAIT_FRAME = 2'd1,
    HOLD_DT    = 2'd2,
    ACTIVE     = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RESET_VAL;
        else         chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RESET_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_pin_filter.sv
module pwrseq_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_CYCLES  = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic pin_pd
);
  localparam int CW = $clog2(LOW_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOW_CYCLES);

  logic          pin_s;
  logic [CW-1:0] low_cnt;

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(pin_n), .q(pin_s)
  );

  // saturating count of consecutive low samples
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                low_cnt <= CNT_MAX;
    else if (pin_s)             low_cnt <= '0;
    else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
  end

  assign pin_pd = (low_cnt == CNT_MAX);

  // R1: a high sample always withdraws the request on the next edge
  a_r1_high_clears: assert property (@(posedge clk) disable iff (!arst_n)
    pin_s |=> !pin_pd);
  // R1: the request only appears after the full run of low samples
  a_r1_full_run: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pin_pd) |-> ($past(low_cnt) == CW'(LOW_CYCLES - 1)) && !$past(pin_s));
endmodule

// File: rtl/pwrseq_frame_detect.sv
module pwrseq_frame_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int N_STROBES   = 2
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic [N_STROBES-1:0] strobe,
  output logic [N_STROBES-1:0] rise
);
  generate
    for (genvar i = 0; i < N_STROBES; i++) begin : g_strobe
      logic s_q, s_prev;
      pwrseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk(clk), .arst_n(arst_n), .d(strobe[i]), .q(s_q)
      );
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_prev <= 1'b0;
        else         s_prev <= s_q;
      end
      assign rise[i] = s_q & ~s_prev;

      // R5: edges are single-cycle events
      a_r5_edge_single: assert property (@(posedge clk) disable iff (!arst_n)
        rise[i] |=> !rise[i]);
    end
  endgenerate
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int HOLD_FRAMES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pd_req,
  input  logic       frame_any,
  input  logic       tx_edge,
  output pwr_state_e state,
  output logic       core_rst
);
  localparam int HW = $clog2(HOLD_FRAMES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_FRAMES - 1);

  pwr_state_e    nxt;
  logic [HW-1:0] hold_cnt;

  always_comb begin
    nxt = state;
    if (pd_req) nxt = PWR_DOWN;
    else begin
      unique case (state)
        PWR_DOWN:   nxt = WAIT_FRAME;
        WAIT_FRAME: if (frame_any) nxt = HOLD_DT;
        HOLD_DT:    if (tx_edge && hold_cnt == HOLD_LAST) nxt = ACTIVE;
        ACTIVE:     nxt = ACTIVE;
        default:    nxt = PWR_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= PWR_DOWN;
      core_rst <= 1'b0;
      hold_cnt <= '0;
    end else begin
      state    <= nxt;
      core_rst <= (state == PWR_DOWN) && (nxt == WAIT_FRAME);
      if (state != HOLD_DT)  hold_cnt <= '0;
      else if (tx_edge)      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R9: any request lands in power-down on the next edge
  a_r9_pd_any_state: assert property (@(posedge clk) disable iff (!arst_n)
    pd_req |=> state == PWR_DOWN);
  // R6: reset pulse lasts one cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |=> !core_rst);
  // R5: power-down never skips the frame wait
  a_r5_no_skip: assert property (@(posedge clk) disable iff (!arst_n)
    state == PWR_DOWN |=> state == PWR_DOWN || state == WAIT_FRAME);
  // R7: hold phase is left only by a transmit edge or a request
  a_r7_hold_stays: assert property (@(posedge clk) disable iff (!arst_n)
    (state == HOLD_DT && !tx_edge && !pd_req) |=> state == HOLD_DT);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_CYCLES  = 10,
  parameter int HOLD_FRAMES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pd_pin_n,
  input  logic fs_tx,
  input  logic fs_rx,
  input  logic reg_pd_analog,
  input  logic reg_pd_digital,
  output logic analog_en,
  output logic digital_en,
  output logic core_rst,
  output logic oe_scp,
  output logic oe_dt
);
  localparam int N_STROBES = 2;
  localparam int TX = 0;
  localparam int RX = 1;

  logic                 pin_pd;
  logic [N_STROBES-1:0] rise;
  logic                 frame_ok;
  logic                 chip_up;
  pwr_state_e           state;

  pwrseq_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_CYCLES(LOW_CYCLES)) u_pin (
    .clk(clk), .arst_n(arst_n), .pin_n(pd_pin_n), .pin_pd(pin_pd)
  );

  pwrseq_frame_detect #(.SYNC_STAGES(SYNC_STAGES), .N_STROBES(N_STROBES)) u_frame (
    .clk(clk), .arst_n(arst_n), .strobe({fs_rx, fs_tx}), .rise(rise)
  );

  pwrseq_fsm #(.HOLD_FRAMES(HOLD_FRAMES)) u_fsm (
    .clk(clk), .arst_n(arst_n),
    .pd_req(pin_pd | reg_pd_digital),
    .frame_any(|rise), .tx_edge(rise[TX]),
    .state(state), .core_rst(core_rst)
  );

  // analog side: only the pin and frames matter, not the digital register bit
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 frame_ok <= 1'b0;
    else if (pin_pd)             frame_ok <= 1'b0;
    else if (rise[TX] | rise[RX]) frame_ok <= 1'b1;
  end

  assign chip_up    = (state == HOLD_DT) || (state == ACTIVE);
  assign digital_en = chip_up;
  assign oe_scp     = chip_up;
  assign oe_dt      = (state == ACTIVE);
  assign analog_en  = frame_ok & ~pin_pd & ~reg_pd_analog;

  // R7: data pin only turns on straight out of the hold phase
  a_r7_dt_after_hold: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(oe_dt) |-> $past(state) == HOLD_DT);
  // R4: pin power-down silences the analog side at once
  a_r4_analog_off: assert property (@(posedge clk) disable iff (!arst_n)
    pin_pd |-> !analog_en);
endmodule

// File: tb/pwrseq_ctrl_test.sv
module pwrseq_ctrl_test;
  logic clk = 1'b0;
  logic arst_n, pd_pin_n, fs_tx, fs_rx, reg_pd_analog, reg_pd_digital;
  logic analog_en, digital_en, core_rst, oe_scp, oe_dt;

  int checks = 0;
  int errors = 0;
  int rst_pulses = 0;
  int rst_long = 0;
  logic rst_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrseq_ctrl uut (
    .clk(clk), .arst_n(arst_n), .pd_pin_n(pd_pin_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .reg_pd_analog(reg_pd_analog), .reg_pd_digital(reg_pd_digital),
    .analog_en(analog_en), .digital_en(digital_en), .core_rst(core_rst),
    .oe_scp(oe_scp), .oe_dt(oe_dt)
  );

  always @(negedge clk) begin
    if (core_rst) rst_pulses++;
    if (core_rst && rst_prev) rst_long++;
    rst_prev = core_rst;
  end

  // {expect power-down, low pulse length}
  localparam logic [8:0] VEC [5] = '{{1'b0, 8'd3}, {1'b0, 8'd9}, {1'b1, 8'd10},
                                     {1'b1, 8'd11}, {1'b1, 8'd25}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit tx);
    if (tx) fs_tx = 1'b1; else fs_rx = 1'b1;
    tick(4);
    fs_tx = 1'b0; fs_rx = 1'b0;
    tick(8);
  endtask

  task automatic low_pulse(input int n);
    pd_pin_n = 1'b0;
    tick(n);
    pd_pin_n = 1'b1;
  endtask

  task automatic bring_up();
    repeat (3) strobe(1'b1);
  endtask

  initial begin
    arst_n = 1'b0; pd_pin_n = 1'b1; fs_tx = 1'b0; fs_rx = 1'b0;
    reg_pd_analog = 1'b0; reg_pd_digital = 1'b0;
    tick(3);
    // R8 reset state
    chk({analog_en, digital_en, core_rst, oe_scp, oe_dt} == 5'b0, "R8",
        {analog_en, digital_en, core_rst, oe_scp, oe_dt}, 0);
    arst_n = 1'b1;
    tick(12);
    chk(digital_en == 1'b0, "R5 no frame", digital_en, 0);
    chk(oe_dt == 1'b0, "R5 no frame dt", oe_dt, 0);
    chk(rst_pulses == 1, "R6 first wake", rst_pulses, 1);
    strobe(1'b1);
    chk(digital_en && oe_scp, "R5 woke", {digital_en, oe_scp}, 3);
    chk(oe_dt == 1'b0, "R7 hold 0", oe_dt, 0);
    strobe(1'b1);
    chk(oe_dt == 1'b0, "R7 hold 1", oe_dt, 0);
    strobe(1'b1);
    chk(oe_dt == 1'b1, "R7 released", oe_dt, 1);
    chk(analog_en == 1'b1, "R3 analog up", analog_en, 1);

    // R1 threshold table
    for (int i = 0; i < 5; i++) begin
      rst_pulses = 0;
      low_pulse(int'(VEC[i][7:0]));
      tick(20);
      chk(oe_dt == !VEC[i][8], "R1 dt", oe_dt, int'(!VEC[i][8]));
      chk(rst_pulses == int'(VEC[i][8]), "R1 R6 rst count", rst_pulses, int'(VEC[i][8]));
      if (VEC[i][8]) begin
        bring_up();
        chk(oe_dt == 1'b1, "R7 back up", oe_dt, 1);
      end
    end

    // R3 analog register bit alone
    reg_pd_analog = 1'b1; tick(2);
    chk(analog_en == 1'b0, "R3 analog off", analog_en, 0);
    chk(digital_en && oe_dt, "R3 digital kept", {digital_en, oe_dt}, 3);
    reg_pd_analog = 1'b0; tick(2);

    // R2 digital register bit
    rst_pulses = 0;
    reg_pd_digital = 1'b1; tick(3);
    chk({digital_en, oe_scp, oe_dt} == 3'b0, "R2 off", {digital_en, oe_scp, oe_dt}, 0);
    chk(analog_en == 1'b1, "R3 analog independent", analog_en, 1);
    reg_pd_digital = 1'b0; tick(5);
    chk(oe_dt == 1'b0 && rst_pulses == 1, "R2 R6 rewake", rst_pulses, 1);
    bring_up();
    chk(oe_dt == 1'b1, "R2 back up", oe_dt, 1);

    // R4 pin power-down holds everything off
    pd_pin_n = 1'b0; tick(16);
    chk({analog_en, digital_en, oe_scp, oe_dt} == 4'b0, "R4 all off",
        {analog_en, digital_en, oe_scp, oe_dt}, 0);
    strobe(1'b1);
    chk(digital_en == 1'b0, "R5 pin low blocks wake", digital_en, 0);
    pd_pin_n = 1'b1; tick(6);

    // R7 receive strobes wake but do not release the data pin
    repeat (4) strobe(1'b0);
    chk(digital_en == 1'b1, "R5 rx wake", digital_en, 1);
    chk(oe_dt == 1'b0, "R7 rx not counted", oe_dt, 0);
    // R9 power-down from the hold phase
    low_pulse(12); tick(4);
    chk(digital_en == 1'b0, "R9 from hold", digital_en, 0);
    tick(10);
    bring_up();
    chk(oe_dt == 1'b1, "R9 recovered", oe_dt, 1);
    chk(rst_long == 0, "R6 single cycle", rst_long, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule